// File: doc/BRIEF.md
# Serial EEPROM Slave over SPI

This block is an SPI slave that behaves like a small byte-addressed serial EEPROM. The slave runs on a system clock and oversamples the serial clock, the active-low select and the input data. It samples input data on the rising serial clock edge and changes output data on the falling edge, as in SPI mode 0. Every transaction starts with a one-byte instruction. The instruction selects one of these commands: set or clear the write-enable latch, read or write the status byte, read the array, or write a page of the array. The array holds 256 or 512 bytes. It is a synthesizable register array, and a parameterised counter of system clocks stands in for the internal programming time.

For the 512-byte variant, the ninth address bit travels in bit 3 of the instruction. An instruction the slave does not know makes it drop off the bus until the select is released. While a write cycle runs, the slave accepts only the status read. Writes need the write-enable latch. They are also filtered by two protection bits, which keep their value through a reset of the rest of the state.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, the status byte reads 0xF0 | (BP << 2). A reset clears the write-enable latch and the busy flag, but the two protection bits keep the value they had before the reset.
- R2: Instruction 0000x110 sets the write-enable latch and 0000x100 clears it. Bit 3 (x) is don't-care, so 0x0E has the same effect as 0x06.
- R3: Instruction 0000x101 returns the status byte. Its layout is bit 0 busy, bit 1 write-enable latch, bit 2 BP0, bit 3 BP1, and bits 7..4 always 1. The byte is sent again on every further 8 serial clocks while select stays low, and each copy is refreshed.
- R4: Instruction 0000A011 followed by an address byte returns array data MSB first. The address advances by one after each byte and wraps from the last location to 0.
- R5: With ADDR_BITS=9, bit 3 (A) of the read and write instructions is address bit 8. With ADDR_BITS=8 that bit is ignored.
- R6: Instruction 0000A010, an address byte and data bytes write the array. The low 4 address bits advance and wrap inside a 16-byte page. Data is committed only when select rises on a byte boundary.
- R7: A write or a status write issued while the write-enable latch is 0 changes nothing and starts no write cycle.
- R8: The status-write instruction 0000x001 loads BP1:BP0 from bits 3:2 of its data byte. BP=00 protects nothing, 01 protects the top quarter of the array, 10 the top half and 11 all of it. Bytes aimed at protected locations are dropped.
- R9: The busy flag is 1 for exactly WRITE_CYCLES system clocks after the select rise that ends an accepted write. The write-enable latch clears in the same clock in which busy falls.
- R10: While busy, every instruction except the status read is ignored. Ignored reads do not drive the output, and ignored writes change no data.
- R11: An instruction whose upper nibble is not 0000, or whose low bits are 000 or 111, makes the slave ignore the bus and float its output until select rises.
- R12: The output is driven (miso_oe=1) only during the data phase of an array or status read, and is released after select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling and the write-cycle timer |
| rst_n | input | 1 | Asynchronous active-low reset (protection bits excluded) |
| cs_n | input | 1 | Active-low slave select |
| sclk | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the slave |
| miso | output | 1 | Serial data out of the slave |
| miso_oe | output | 1 | Output enable for miso; 0 means high impedance |

## Verification
Two events can land in the same system clock: the internal write cycle ends, and the status reader loads the next status byte. When they coincide, the busy flag and the auto-clear of the write-enable latch must change together. The bench provokes this by streaming the status byte without a break throughout every write cycle. It accepts only two values: busy with the latch set, or idle with the latch clear. A mixed value fails the check, and the checker asserts that the latch is low in the clock where busy falls.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

   typedef enum logic [2:0] {
      ST_OPC,
      ST_ADDR,
      ST_RD,
      ST_WR,
      ST_SRRD,
      ST_SRWR,
      ST_SKIP
   } phase_e;

   localparam logic [2:0] OP_LATCH_ON  = 3'b110;
   localparam logic [2:0] OP_LATCH_OFF = 3'b100;
   localparam logic [2:0] OP_STAT_RD   = 3'b101;
   localparam logic [2:0] OP_STAT_WR   = 3'b001;
   localparam logic [2:0] OP_MEM_RD    = 3'b011;
   localparam logic [2:0] OP_MEM_WR    = 3'b010;

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
   parameter int              WIDTH   = 3,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_ee_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_ee_protect.sv
module spi_ee_protect #(
   parameter int ADDR_BITS = 9
) (
   input  logic [1:0]           bp,
   input  logic [ADDR_BITS-1:0] addr,
   output logic                 locked
);

   localparam int DEPTH = 1 << ADDR_BITS;
   localparam logic [ADDR_BITS-1:0] HALF_BASE = ADDR_BITS'(DEPTH / 2);
   localparam logic [ADDR_BITS-1:0] QTR_BASE  = ADDR_BITS'(DEPTH - DEPTH / 4);

   always_comb begin
      unique case (bp)
         2'b00:   locked = 1'b0;
         2'b01:   locked = (addr >= QTR_BASE);
         2'b10:   locked = (addr >= HALF_BASE);
         default: locked = 1'b1;
      endcase
   end

endmodule

// File: rtl/spi_ee_wtimer.sv
module spi_ee_wtimer #(
   parameter int CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("spi_ee_wtimer: CYCLES must be positive");
   end

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
   assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
   import spi_ee_pkg::*;
#(
   parameter int         ADDR_BITS    = 9,
   parameter int         PAGE_BITS    = 4,
   parameter int         WRITE_CYCLES = 200,
   parameter int         SYNC_STAGES  = 2,
   parameter logic [1:0] BP_POWERUP   = 2'b00
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic mosi,
   output logic miso,
   output logic miso_oe
);

   localparam int DEPTH = 1 << ADDR_BITS;
   localparam int PAGE  = 1 << PAGE_BITS;

   if (ADDR_BITS < 8 || ADDR_BITS > 9) begin : g_bad_aw
      $error("spi_eeprom_slave: ADDR_BITS must be 8 or 9");
   end
   if (PAGE_BITS < 1 || PAGE_BITS > 8) begin : g_bad_pb
      $error("spi_eeprom_slave: PAGE_BITS out of range");
   end

   // ---------------- input oversampling ----------------
   logic cs_s, sclk_s, mosi_s, cs_d, sclk_d;

   spi_ee_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, mosi}),
      .q     ({cs_s, sclk_s, mosi_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d   <= 1'b1;
         sclk_d <= 1'b0;
      end else begin
         cs_d   <= cs_s;
         sclk_d <= sclk_s;
      end
   end

   logic cs_act, cs_end, sclk_rise, sclk_fall;
   assign cs_act    = ~cs_s;
   assign cs_end    = cs_s & ~cs_d;
   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;

   // ---------------- state ----------------
   phase_e                state_q;
   logic [2:0]            bit_q;
   logic [6:0]            rx_q;
   logic [7:0]            tx_q;
   logic                  oe_q, wel_q, arm_q, wr_q, hi_q, sr_got;
   logic [1:0]            sr_new;
   logic [ADDR_BITS-1:0]  addr_q;
   logic [PAGE-1:0]       pmask;
   logic [7:0]            pbuf [PAGE];
   logic [7:0]            mem  [DEPTH];
   logic [1:0]            bp_q = BP_POWERUP;

   logic                  busy, cyc_done;
   logic [7:0]            rx_byte, status;
   logic                  byte_done, opc_a8, wr_take;
   logic [ADDR_BITS-1:0]  addr_load;
   logic                  cycle_start, start_wr, start_sr;

   assign rx_byte   = {rx_q, mosi_s};
   assign byte_done = cs_act & sclk_rise & (state_q != ST_SKIP) & (bit_q == 3'd7);
   assign wr_take   = byte_done & (state_q == ST_WR) & arm_q;
   assign status    = {4'hF, bp_q, wel_q, busy};

   // ninth address bit: taken from the instruction only in the large variant
   if (ADDR_BITS == 9) begin : g_a8
      assign opc_a8    = rx_byte[3];
      assign addr_load = {hi_q, rx_byte};
   end else begin : g_a7
      assign opc_a8    = 1'b0;
      assign addr_load = rx_byte[ADDR_BITS-1:0];
   end

   assign cycle_start = cs_end & arm_q & (bit_q == 3'd0) & ~busy &
                        (((state_q == ST_WR) & (|pmask)) | ((state_q == ST_SRWR) & sr_got));
   assign start_wr    = cycle_start & (state_q == ST_WR);
   assign start_sr    = cycle_start & (state_q == ST_SRWR);

   spi_ee_wtimer #(.CYCLES(WRITE_CYCLES)) u_wtimer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (cycle_start),
      .busy  (busy),
      .done  (cyc_done)
   );

   // ---------------- protocol engine ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OPC;
         bit_q   <= '0;
         rx_q    <= '0;
         tx_q    <= '1;
         oe_q    <= 1'b0;
         wel_q   <= 1'b0;
         arm_q   <= 1'b0;
         wr_q    <= 1'b0;
         hi_q    <= 1'b0;
         sr_got  <= 1'b0;
         sr_new  <= '0;
         addr_q  <= '0;
         pmask   <= '0;
      end else begin
         if (!cs_act) begin
            state_q <= ST_OPC;
            bit_q   <= '0;
            oe_q    <= 1'b0;
            arm_q   <= 1'b0;
            sr_got  <= 1'b0;
            pmask   <= '0;
         end else begin
            if (sclk_rise && state_q != ST_SKIP) begin
               rx_q  <= rx_byte[6:0];
               bit_q <= bit_q + 1'b1;
            end
            if (byte_done) begin
               unique case (state_q)
                  ST_OPC: begin
                     if (rx_byte[7:4] != 4'h0) begin
                        state_q <= ST_SKIP;
                     end else if (busy) begin
                        state_q <= (rx_byte[2:0] == OP_STAT_RD) ? ST_SRRD : ST_SKIP;
                     end else begin
                        unique case (rx_byte[2:0])
                           OP_LATCH_ON:  begin wel_q <= 1'b1; state_q <= ST_SKIP; end
                           OP_LATCH_OFF: begin wel_q <= 1'b0; state_q <= ST_SKIP; end
                           OP_STAT_RD:   state_q <= ST_SRRD;
                           OP_STAT_WR:   begin arm_q <= wel_q; state_q <= ST_SRWR; end
                           OP_MEM_RD:    begin hi_q <= opc_a8; wr_q <= 1'b0; state_q <= ST_ADDR; end
                           OP_MEM_WR:    begin hi_q <= opc_a8; wr_q <= 1'b1; arm_q <= wel_q;
                                               state_q <= ST_ADDR; end
                           default:      state_q <= ST_SKIP;
                        endcase
                     end
                  end
                  ST_ADDR: begin
                     addr_q  <= addr_load;
                     state_q <= wr_q ? ST_WR : ST_RD;
                  end
                  ST_WR: begin
                     if (arm_q) begin
                        pmask[addr_q[PAGE_BITS-1:0]] <= 1'b1;
                        addr_q[PAGE_BITS-1:0]        <= addr_q[PAGE_BITS-1:0] + 1'b1;
                     end
                  end
                  ST_SRWR: begin
                     if (!sr_got) begin
                        sr_new <= rx_byte[3:2];
                        sr_got <= 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
            if (sclk_fall && state_q != ST_SKIP) begin
               if (bit_q == 3'd0 && state_q == ST_RD) begin
                  tx_q   <= mem[addr_q];
                  addr_q <= addr_q + 1'b1;
                  oe_q   <= 1'b1;
               end else if (bit_q == 3'd0 && state_q == ST_SRRD) begin
                  tx_q <= status;
                  oe_q <= 1'b1;
               end else begin
                  tx_q <= {tx_q[6:0], 1'b1};
               end
            end
         end
         if (cyc_done) wel_q <= 1'b0;
      end
   end

   // protection bits survive the reset of everything else
   always_ff @(posedge clk) begin
      if (start_sr) bp_q <= sr_new;
   end

   // ---------------- page buffer and array commit ----------------
   always_ff @(posedge clk) begin
      if (wr_take) pbuf[addr_q[PAGE_BITS-1:0]] <= rx_byte;
   end

   logic [PAGE-1:0] slot_lock;

   for (genvar g = 0; g < PAGE; g++) begin : g_slot
      spi_ee_protect #(.ADDR_BITS(ADDR_BITS)) u_prot (
         .bp     (bp_q),
         .addr   ({addr_q[ADDR_BITS-1:PAGE_BITS], PAGE_BITS'(g)}),
         .locked (slot_lock[g])
      );
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < PAGE; i++) begin
         if (start_wr && pmask[i] && !slot_lock[i])
            mem[{addr_q[ADDR_BITS-1:PAGE_BITS], PAGE_BITS'(i)}] <= pbuf[i];
      end
   end

   assign miso    = tx_q[7];
   assign miso_oe = oe_q;

endmodule

// File: rtl/spi_eeprom_slave_chk.sv
module spi_eeprom_slave_chk
   import spi_ee_pkg::*;
#(
   parameter int WRITE_CYCLES = 200
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_act,
   input logic       wip,
   input logic       wel,
   input logic       start,
   input logic [1:0] bp,
   input phase_e     state,
   input logic       miso_oe
);

   logic [31:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   run_cnt <= '0;
      else if (wip) run_cnt <= run_cnt + 1;
      else          run_cnt <= '0;
   end

   a_r9_wel_drops_with_wip: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |-> !wel);

   a_r9_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |-> (run_cnt == 32'(WRITE_CYCLES)));

   a_r7_start_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> wel);

   a_r10_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !wip);

   a_r8_bp_moves_only_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(bp));

   a_r12_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !miso_oe);

   a_r11_skip_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !miso_oe);

endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_act  (cs_act),
   .wip     (busy),
   .wel     (wel_q),
   .start   (cycle_start),
   .bp      (bp_q),
   .state   (state_q),
   .miso_oe (miso_oe)
);

// File: tb/spi_eeprom_slave_bench.sv
module spi_eeprom_slave_bench;

   localparam int HALF = 8;
   localparam int WCYC = 300;
   localparam int NVEC = 8;
   // {address, data}
   localparam logic [16:0] VEC [NVEC] = '{
      {9'h000, 8'h5A}, {9'h0FF, 8'hC3}, {9'h100, 8'h96}, {9'h1FF, 8'h3C},
      {9'h123, 8'h01}, {9'h050, 8'h11}, {9'h061, 8'h24}, {9'h0AB, 8'hFE}
   };

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
   logic miso, miso_oe;
   int   n_run = 0, n_fail = 0;
   bit   finished = 1'b0;

   always #4 clk = ~clk;

   spi_eeprom_slave #(.ADDR_BITS(9), .WRITE_CYCLES(WCYC)) u_spi_eeprom_slave (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
      .miso(miso), .miso_oe(miso_oe)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] d, output logic [7:0] r, output logic oe0);
      r = '0; oe0 = 1'b0;
      for (int b = 7; b >= 0; b--) begin
         mosi = d[b];
         tick(HALF);
         r[b] = miso;
         if (b == 7) oe0 = miso_oe;
         sclk = 1'b1;
         tick(HALF);
         sclk = 1'b0;
      end
   endtask

   task automatic sel();   cs_n = 1'b0; tick(HALF); endtask
   task automatic desel(); tick(HALF); cs_n = 1'b1; tick(3*HALF); endtask

   task automatic send(input logic [7:0] d);
      logic [7:0] r; logic o;
      xfer(d, r, o);
   endtask

   task automatic cmd(input logic [7:0] op);
      sel(); send(op); desel();
   endtask

   task automatic status(output logic [7:0] st);
      logic o;
      sel(); send(8'h05); xfer(8'h00, st, o); desel();
   endtask

   task automatic wrsr(input logic [7:0] v);
      sel(); send(8'h01); send(v); desel();
   endtask

   task automatic wr(input logic [8:0] a, input logic [7:0] d);
      sel(); send({4'h0, a[8], 3'b010}); send(a[7:0]); send(d); desel();
   endtask

   task automatic rd(input logic [8:0] a, output logic [7:0] d, output logic o);
      sel(); send({4'h0, a[8], 3'b011}); send(a[7:0]); xfer(8'h00, d, o); desel();
   endtask

   // stream status until idle: busy bytes must show latch set, idle byte latch clear (R9, R3)
   task automatic wait_idle(input logic [7:0] idle_exp, input bit need_busy);
      logic [7:0] st; logic o; int busy_n;
      busy_n = 0;
      sel(); send(8'h05);
      for (int k = 0; k < 40; k++) begin
         xfer(8'h00, st, o);
         if (st[0]) begin
            busy_n++;
            check("R9 busy status byte", st, idle_exp | 8'h03);
         end else break;
      end
      check("R9 idle status after cycle", st, idle_exp);
      if (need_busy) check("R9 write cycle observed", 8'(busy_n > 0), 8'h01);
      desel();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] st, d;
      logic o;
      tick(5); rst_n = 1'b1; tick(5);

      check("R12 output released when idle", {7'b0, miso_oe}, 8'h00);
      status(st); check("R1 status after reset", st, 8'hF0);

      cmd(8'h06); status(st); check("R2 latch set", st, 8'hF2);
      cmd(8'h04); status(st); check("R2 latch cleared", st, 8'hF0);
      cmd(8'h0E); status(st); check("R2 bit3 don't-care on set", st, 8'hF2);
      cmd(8'h04);

      // vector table: write each, then read each back
      for (int i = 0; i < NVEC; i++) begin
         cmd(8'h06);
         wr(VEC[i][16:8], VEC[i][7:0]);
         wait_idle(8'hF0, 1'b1);
      end
      for (int i = 0; i < NVEC; i++) begin
         rd(VEC[i][16:8], d, o);
         check("R5 R6 readback at address", d, VEC[i][7:0]);
         check("R12 output driven in read data", {7'b0, o}, 8'h01);
      end

      // R4 streaming read wraps from the top to 0
      sel(); send(8'h0B); send(8'hFF);
      xfer(8'h00, d, o); check("R4 read top location", d, 8'h3C);
      xfer(8'h00, d, o); check("R4 wrap to location 0", d, 8'h5A);
      desel();

      // R6 page wrap of the low address bits
      cmd(8'h06);
      sel(); send(8'h02); send(8'h2E); send(8'hA1); send(8'hA2); send(8'hA3); desel();
      wait_idle(8'hF0, 1'b1);
      rd(9'h02E, d, o); check("R6 page byte 0x2E", d, 8'hA1);
      rd(9'h02F, d, o); check("R6 page byte 0x2F", d, 8'hA2);
      rd(9'h020, d, o); check("R6 page wrap to 0x20", d, 8'hA3);

      // R7 write without latch
      wr(9'h050, 8'h77);
      status(st); check("R7 no cycle without latch", st, 8'hF0);
      rd(9'h050, d, o); check("R7 data unchanged", d, 8'h11);

      // R10 instructions during busy
      cmd(8'h06); wr(9'h060, 8'h42);
      wr(9'h061, 8'hEE);
      wait_idle(8'hF0, 1'b0);
      rd(9'h061, d, o); check("R10 busy write ignored", d, 8'h24);
      rd(9'h060, d, o); check("R10 first write landed", d, 8'h42);
      cmd(8'h06); wr(9'h070, 8'h05);
      sel(); send(8'h03); send(8'h70); xfer(8'h00, d, o); desel();
      check("R10 busy read leaves output off", {7'b0, o}, 8'h00);
      wait_idle(8'hF0, 1'b0);

      // R8 protection levels
      cmd(8'h06); wrsr(8'h04); wait_idle(8'hF4, 1'b1);
      status(st); check("R8 BP=01 in status", st, 8'hF4);
      cmd(8'h06); wr(9'h1FF, 8'h99); wait_idle(8'hF4, 1'b1);
      rd(9'h1FF, d, o); check("R8 top quarter locked", d, 8'h3C);
      cmd(8'h06); wr(9'h17F, 8'h88); wait_idle(8'hF4, 1'b1);
      rd(9'h17F, d, o); check("R8 below quarter writable", d, 8'h88);
      cmd(8'h06); wrsr(8'h08); wait_idle(8'hF8, 1'b1);
      cmd(8'h06); wr(9'h100, 8'h55); wait_idle(8'hF8, 1'b1);
      rd(9'h100, d, o); check("R8 top half locked", d, 8'h96);
      cmd(8'h06); wr(9'h0FF, 8'h66); wait_idle(8'hF8, 1'b1);
      rd(9'h0FF, d, o); check("R8 lower half writable", d, 8'h66);
      cmd(8'h06); wrsr(8'h0C); wait_idle(8'hFC, 1'b1);
      cmd(8'h06); wr(9'h000, 8'hAA); wait_idle(8'hFC, 1'b1);
      rd(9'h000, d, o); check("R8 whole array locked", d, 8'h5A);
      wrsr(8'h00);
      status(st); check("R7 status write without latch", st, 8'hFC);

      // R1 reset keeps protection, clears latch
      cmd(8'h06); status(st); check("R1 latch set before reset", st, 8'hFE);
      rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
      status(st); check("R1 BP retained, latch cleared", st, 8'hFC);
      cmd(8'h06); wrsr(8'h00); wait_idle(8'hF0, 1'b1);

      // R11 unknown instructions
      sel(); send(8'hC6); xfer(8'h06, d, o);
      check("R11 output off after bad opcode", {7'b0, o}, 8'h00);
      desel();
      status(st); check("R11 later byte ignored", st, 8'hF0);
      sel(); send(8'h07); send(8'h03); xfer(8'h00, d, o);
      check("R11 no read after bad opcode", {7'b0, o}, 8'h00);
      desel();

      // R3 repeated status bytes under one select
      sel(); send(8'h05);
      for (int k = 0; k < 3; k++) begin
         xfer(8'h00, st, o);
         check("R3 repeated status", st, 8'hF0);
      end
      desel();
      check("R12 released after select", {7'b0, miso_oe}, 8'h00);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule